// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits between a processor's register bus and a small embedded non-volatile word array. It sequences program and erase work on that array. Software chooses an operation mode through a control register. Changing the mode needs a short unlock ritual: raise the enable bit, write the mode, then drop the enable bit again. After that, a single store to the array port starts the operation, and the mode decides what that store means. It can program one word, program one word and compare it afterwards, stream a burst of words, erase one sector, or erase the whole array.

Completion and failures are reported through sticky status flags. Software clears them by writing ones to a separate clear register. An interrupt line combines the flags with three enable bits. A window given by start and end addresses protects part of the array against modification. The array is a behavioural model: every accepted operation takes a fixed number of clock cycles, erased words read as all ones, and programming can only turn ones into zeros.

Top module: `flashctl_top`

## Requirements
- R1: After reset the status register reads 0x100 (only ready set), control reads 0, window start reads 0xFFFFF, window end reads 0 (an empty window), every array word reads 0xFFFFFFFF, `irq` and `arr_rvalid` are low.
- R2: Register offset 0 is control: bit 0 is the program/erase enable, and bits 6:4 hold the mode (0 read-only, 1 single program, 2 program with compare, 3 sequence, 4 sector erase, 5 full erase). The mode field is written only when the enable bit was already set before the write. Codes 6 and 7 leave the mode unchanged. The enable bit always takes the written value.
- R3: Register offset 1 is status: bit 0 write-protect error, bit 1 protected-area error, bit 2 size error, bit 3 compare mismatch, bit 4 end of operation, bit 5 collision, bit 8 ready. Flags stay set until a write to the clear register (offset 2) has a one in the same position. That write cannot change ready.
- R4: A store to the array in read-only mode sets only the write-protect error. It does not start an operation, does not set end of operation, and leaves the array unchanged.
- R5: An accepted single program starts an operation that keeps ready low for exactly OP_LAT cycles. The stored word then becomes old AND new, and end of operation is set.
- R6: In program-with-compare mode, the mismatch flag is set at completion when old AND new differs from the written data.
- R7: In sequence mode each accepted word sets end of operation. A store made while end of operation is still set is dropped and sets collision. Ready stays low from the first word until the mode is no longer sequence.
- R8: In sector erase mode, a store of any value to any address sets every word of that address's SECTOR_WORDS-aligned sector to all ones. Other words are left unchanged.
- R9: In full erase mode, a store of any value sets every word to all ones.
- R10: Window start (offset 4) and end (offset 5) keep the low 20 bits of the written data. A program or sector erase at a byte address with start <= address <= end sets the protected-area error and end of operation, and leaves the array unchanged. A full erase is refused in the same way whenever start <= end.
- R11: A program-mode store whose byte-enable `arr_be` is not 4'hF sets the size error and end of operation, and leaves the array unchanged.
- R12: While an operation is running, an array read or store sets the collision flag. The store is dropped, and the read returns the contents from before the operation.
- R13: Register offset 3 holds the interrupt enables: bit 0 for errors (status bits 3:0), bit 1 for end of operation, bit 2 for collision. `irq` is high while any enabled flag is set.
- R14: `arr_rdata` and `arr_rvalid` come out one cycle after `arr_rd`, and `arr_rvalid` is high for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| arr_wr | input | 1 | Array store strobe (operation trigger) |
| arr_rd | input | 1 | Array read strobe |
| arr_addr | input | ADDR_W | Array byte address |
| arr_be | input | 4 | Byte enables of the store |
| arr_wdata | input | 32 | Store data |
| arr_rdata | output | 32 | Read data |
| arr_rvalid | output | 1 | Read data valid |
| irq | output | 1 | Interrupt request |

## Verification
Register writes and rejected stores change the state at the clock edge that samples them. Their results are therefore read back at the falling edge right after the strobe drops. An accepted operation holds ready low for OP_LAT cycles after that edge. The bench counts those low samples and checks the array only after ready returns, or, in sequence mode, after end of operation rises. Array reads are queued with their expected words. A monitor on the falling edge compares each one at the single cycle in which `arr_rvalid` is high, one cycle after the read strobe.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;
    typedef enum logic [2:0] {
        MD_RO         = 3'd0,
        MD_PROG       = 3'd1,
        MD_PROG_CMP   = 3'd2,
        MD_SEQ        = 3'd3,
        MD_SECT_ERASE = 3'd4,
        MD_CHIP_ERASE = 3'd5
    } fmode_e;

    typedef enum logic [1:0] {
        OP_PROG     = 2'd0,
        OP_PROG_CMP = 2'd1,
        OP_SECT     = 2'd2,
        OP_CHIP     = 2'd3
    } opkind_e;

    localparam int NFLAGS   = 6;
    localparam int FLG_WP   = 0;
    localparam int FLG_PROT = 1;
    localparam int FLG_SIZE = 2;
    localparam int FLG_MISM = 3;
    localparam int FLG_EOP  = 4;
    localparam int FLG_COL  = 5;
    localparam int RDY_BIT  = 8;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_STAT = 3'd1;
    localparam logic [2:0] RA_CLR  = 3'd2;
    localparam logic [2:0] RA_IEN  = 3'd3;
    localparam logic [2:0] RA_WLO  = 3'd4;
    localparam logic [2:0] RA_WHI  = 3'd5;

    function automatic logic mode_code_ok(input logic [2:0] code);
        return code <= 3'd5;
    endfunction
endpackage

// File: rtl/flashctl_cfg.sv
module flashctl_cfg
    import flashctl_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              pe_en,
    output fmode_e            mode,
    output logic [2:0]        ien,
    output logic [ADDR_W-1:0] win_lo,
    output logic [ADDR_W-1:0] win_hi
);
    typedef struct packed {
        logic              pe_en;
        fmode_e            mode;
        logic [2:0]        ien;
        logic [ADDR_W-1:0] win_lo;
        logic [ADDR_W-1:0] win_hi;
    } cfg_t;

    cfg_t c_d, c_q;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[31:ADDR_W];

    always_comb begin
        c_d = c_q;
        if (reg_wr) begin
            unique case (reg_addr)
                RA_CTRL: begin
                    c_d.pe_en = reg_wdata[0];
                    if (c_q.pe_en && mode_code_ok(reg_wdata[6:4]))
                        c_d.mode = fmode_e'(reg_wdata[6:4]);
                end
                RA_IEN:  c_d.ien    = reg_wdata[2:0];
                RA_WLO:  c_d.win_lo = reg_wdata[ADDR_W-1:0];
                RA_WHI:  c_d.win_hi = reg_wdata[ADDR_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q        <= '0;
            c_q.win_lo <= '1;
        end else begin
            c_q <= c_d;
        end
    end

    assign pe_en  = c_q.pe_en;
    assign mode   = c_q.mode;
    assign ien    = c_q.ien;
    assign win_lo = c_q.win_lo;
    assign win_hi = c_q.win_hi;
endmodule

// File: rtl/flashctl_guard.sv
module flashctl_guard
    import flashctl_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  fmode_e            mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    input  logic [ADDR_W-1:0] win_lo,
    input  logic [ADDR_W-1:0] win_hi,
    output logic              err_wp,
    output logic              err_size,
    output logic              err_prot
);
    logic in_win, win_set, is_prog;

    always_comb begin
        in_win   = (addr >= win_lo) && (addr <= win_hi);
        win_set  = (win_lo <= win_hi);
        is_prog  = (mode == MD_PROG) || (mode == MD_PROG_CMP) || (mode == MD_SEQ);
        err_wp   = (mode == MD_RO);
        err_size = is_prog && (be != 4'hF);
        err_prot = !err_wp && !err_size &&
                   ((mode == MD_CHIP_ERASE) ? win_set : in_win);
    end
endmodule

// File: rtl/flashctl_engine.sv
module flashctl_engine
    import flashctl_pkg::*;
#(
    parameter int WORDS        = 64,
    parameter int SECTOR_WORDS = 16,
    parameter int OP_LAT       = 8,
    parameter int ADDR_W       = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arr_wr,
    input  logic              arr_rd,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic [31:0]       arr_wdata,
    input  fmode_e            mode,
    input  logic              err_wp,
    input  logic              err_size,
    input  logic              err_prot,
    input  logic [NFLAGS-1:0] clr,
    output logic [NFLAGS-1:0] flags,
    output logic              ready,
    output logic              busy,
    output logic [31:0]       rdata,
    output logic              rvalid
);
    localparam int IDX_W = $clog2(WORDS);
    localparam int CNT_W = $clog2(OP_LAT + 1);

    typedef struct packed {
        logic [WORDS-1:0][31:0] mem;
        logic                   busy;
        logic [CNT_W-1:0]       cnt;
        opkind_e                kind;
        logic [IDX_W-1:0]       idx;
        logic [31:0]            data;
        logic [NFLAGS-1:0]      flags;
        logic                   seq_act;
        logic [31:0]            rdata;
        logic                   rvalid;
    } eng_t;

    eng_t s_d, s_q;
    logic [IDX_W-1:0] idx;
    logic unused_addr;

    assign idx         = arr_addr[2 +: IDX_W];
    assign unused_addr = ^{arr_addr[1:0], arr_addr[ADDR_W-1:IDX_W+2]};

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = arr_rd;
        s_d.flags  = s_q.flags & ~clr;

        if (arr_rd) begin
            s_d.rdata = s_q.mem[idx];
            if (s_q.busy) s_d.flags[FLG_COL] = 1'b1;
        end

        if (s_q.busy) begin
            if (s_q.cnt == CNT_W'(1)) begin
                s_d.busy           = 1'b0;
                s_d.cnt            = '0;
                s_d.flags[FLG_EOP] = 1'b1;
                unique case (s_q.kind)
                    OP_PROG: s_d.mem[s_q.idx] = s_q.mem[s_q.idx] & s_q.data;
                    OP_PROG_CMP: begin
                        s_d.mem[s_q.idx] = s_q.mem[s_q.idx] & s_q.data;
                        if ((s_q.mem[s_q.idx] & s_q.data) != s_q.data)
                            s_d.flags[FLG_MISM] = 1'b1;
                    end
                    OP_SECT: begin
                        for (int i = 0; i < WORDS; i++) begin
                            if (i / SECTOR_WORDS == int'(s_q.idx) / SECTOR_WORDS)
                                s_d.mem[i] = '1;
                        end
                    end
                    OP_CHIP: begin
                        for (int i = 0; i < WORDS; i++) s_d.mem[i] = '1;
                    end
                    default: ;
                endcase
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end

        if (arr_wr) begin
            if (s_q.busy) begin
                s_d.flags[FLG_COL] = 1'b1;
            end else if (err_wp) begin
                s_d.flags[FLG_WP] = 1'b1;
            end else if (mode == MD_SEQ && s_q.flags[FLG_EOP]) begin
                s_d.flags[FLG_COL] = 1'b1;
            end else if (err_size) begin
                s_d.flags[FLG_SIZE] = 1'b1;
                s_d.flags[FLG_EOP]  = 1'b1;
            end else if (err_prot) begin
                s_d.flags[FLG_PROT] = 1'b1;
                s_d.flags[FLG_EOP]  = 1'b1;
            end else begin
                s_d.busy = 1'b1;
                s_d.cnt  = CNT_W'(OP_LAT);
                s_d.idx  = idx;
                s_d.data = arr_wdata;
                unique case (mode)
                    MD_PROG_CMP:   s_d.kind = OP_PROG_CMP;
                    MD_SECT_ERASE: s_d.kind = OP_SECT;
                    MD_CHIP_ERASE: s_d.kind = OP_CHIP;
                    default:       s_d.kind = OP_PROG;
                endcase
                if (mode == MD_SEQ) s_d.seq_act = 1'b1;
            end
        end

        if (mode != MD_SEQ) s_d.seq_act = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.mem <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign flags  = s_q.flags;
    assign busy   = s_q.busy;
    assign ready  = !s_q.busy && !s_q.seq_act;
    assign rdata  = s_q.rdata;
    assign rvalid = s_q.rvalid;
endmodule

// File: rtl/flashctl_top.sv
module flashctl_top
    import flashctl_pkg::*;
#(
    parameter int WORDS        = 64,
    parameter int SECTOR_WORDS = 16,
    parameter int OP_LAT       = 8,
    parameter int ADDR_W       = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              arr_wr,
    input  logic              arr_rd,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic [3:0]        arr_be,
    input  logic [31:0]       arr_wdata,
    output logic [31:0]       arr_rdata,
    output logic              arr_rvalid,
    output logic              irq
);
    logic              cfg_pe_en;
    fmode_e            cfg_mode;
    logic [2:0]        cfg_ien;
    logic [ADDR_W-1:0] cfg_win_lo, cfg_win_hi;
    logic              g_wp, g_size, g_prot;
    logic [NFLAGS-1:0] clr_bits, eng_flags;
    logic              eng_ready, eng_busy;

    flashctl_cfg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pe_en(cfg_pe_en), .mode(cfg_mode),
        .ien(cfg_ien), .win_lo(cfg_win_lo), .win_hi(cfg_win_hi)
    );

    flashctl_guard #(.ADDR_W(ADDR_W)) u_guard (
        .mode(cfg_mode), .addr(arr_addr), .be(arr_be),
        .win_lo(cfg_win_lo), .win_hi(cfg_win_hi),
        .err_wp(g_wp), .err_size(g_size), .err_prot(g_prot)
    );

    assign clr_bits = (reg_wr && reg_addr == RA_CLR) ? reg_wdata[NFLAGS-1:0] : '0;

    flashctl_engine #(
        .WORDS(WORDS), .SECTOR_WORDS(SECTOR_WORDS),
        .OP_LAT(OP_LAT), .ADDR_W(ADDR_W)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .arr_wr(arr_wr), .arr_rd(arr_rd),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .mode(cfg_mode),
        .err_wp(g_wp), .err_size(g_size), .err_prot(g_prot), .clr(clr_bits),
        .flags(eng_flags), .ready(eng_ready), .busy(eng_busy),
        .rdata(arr_rdata), .rvalid(arr_rvalid)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL: begin
                reg_rdata[0]   = cfg_pe_en;
                reg_rdata[6:4] = cfg_mode;
            end
            RA_STAT: begin
                reg_rdata[NFLAGS-1:0] = eng_flags;
                reg_rdata[RDY_BIT]    = eng_ready;
            end
            RA_IEN:  reg_rdata[2:0] = cfg_ien;
            RA_WLO:  reg_rdata = 32'(cfg_win_lo);
            RA_WHI:  reg_rdata = 32'(cfg_win_hi);
            default: ;
        endcase
    end

    assign irq = (cfg_ien[0] && |eng_flags[FLG_MISM:FLG_WP]) ||
                 (cfg_ien[1] && eng_flags[FLG_EOP]) ||
                 (cfg_ien[2] && eng_flags[FLG_COL]);
endmodule

// File: rtl/flashctl_sva.sv
module flashctl_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic       clr_eop_bit,
    input logic       arr_wr,
    input logic       arr_rd,
    input logic       pe_en,
    input logic [2:0] mode,
    input logic       wp_flag,
    input logic       eop_flag,
    input logic       col_flag,
    input logic       ready,
    input logic       busy
);
    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && !pe_en) |=> $stable(mode)); // R2

    AST_EOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_flag && !(reg_wr && reg_addr == 3'd2 && clr_eop_bit)) |=> eop_flag); // R3

    AST_RO_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr && mode == 3'd0 && !busy) |=> (wp_flag && !busy)); // R4

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ready); // R5

    AST_COL_ON_BUSY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd && busy) |=> col_flag); // R12
endmodule

bind flashctl_top flashctl_sva u_sva (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .clr_eop_bit(reg_wdata[4]), .arr_wr(arr_wr), .arr_rd(arr_rd),
    .pe_en(cfg_pe_en), .mode(cfg_mode), .wp_flag(eng_flags[0]),
    .eop_flag(eng_flags[4]), .col_flag(eng_flags[5]),
    .ready(eng_ready), .busy(eng_busy)
);

// File: tb/sim_flashctl_top.sv
module sim_flashctl_top;
    localparam int LAT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        arr_wr = 1'b0, arr_rd = 1'b0;
    logic [19:0] arr_addr = '0;
    logic [3:0]  arr_be = 4'hF;
    logic [31:0] arr_wdata = '0;
    logic [31:0] arr_rdata;
    logic        arr_rvalid, irq;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] model [64];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    flashctl_top #(.WORDS(64), .SECTOR_WORDS(16), .OP_LAT(LAT), .ADDR_W(20)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .arr_wr(arr_wr),
        .arr_rd(arr_rd), .arr_addr(arr_addr), .arr_be(arr_be),
        .arr_wdata(arr_wdata), .arr_rdata(arr_rdata), .arr_rvalid(arr_rvalid),
        .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: R14 read data is due one cycle after the strobe
    always @(negedge clk) begin
        if (arr_rvalid) begin
            if (exp_q.size() == 0) check("R14 unexpected rvalid", 32'd1, 32'd0);
            else check(tag_q.pop_front(), arr_rdata, exp_q.pop_front());
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic reg_check(string tag, input logic [2:0] a, input logic [31:0] exp);
        reg_addr = a; #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic set_mode(input logic [2:0] m);
        reg_write(3'd0, 32'h1);
        reg_write(3'd0, {25'd0, m, 4'h1});
        reg_write(3'd0, {25'd0, m, 4'h0});
    endtask

    task automatic arr_store(input int w, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk); arr_wr = 1'b1; arr_addr = 20'(w * 4); arr_wdata = d; arr_be = be;
        @(negedge clk); arr_wr = 1'b0; arr_be = 4'hF;
    endtask

    task automatic arr_load(string tag, input int w);
        exp_q.push_back(model[w]); tag_q.push_back(tag);
        @(negedge clk); arr_rd = 1'b1; arr_addr = 20'(w * 4);
        @(negedge clk); arr_rd = 1'b0;
    endtask

    task automatic wait_bit(input int b, output int n);
        n = 0; reg_addr = 3'd1; #1;
        while (!reg_rdata[b] && n < 1000) begin
            @(negedge clk); #1; n++;
        end
    endtask

    task automatic clear_all();
        reg_write(3'd2, 32'h3F);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        for (int i = 0; i < 64; i++) model[i] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_check("R1 status", 3'd1, 32'h100);
        reg_check("R1 ctrl", 3'd0, 32'h0);
        reg_check("R1 win start", 3'd4, 32'hFFFFF);
        reg_check("R1 win end", 3'd5, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 rvalid", {31'd0, arr_rvalid}, 32'd0);
        arr_load("R1 erased word", 5);

        // R4 store in read-only mode
        arr_store(3, 32'h0, 4'hF);
        reg_check("R4 wp flag only", 3'd1, 32'h101);
        arr_load("R4 array unchanged", 3);
        repeat (3) @(negedge clk);
        reg_check("R3 flag sticky", 3'd1, 32'h101);
        reg_write(3'd2, 32'h1FF);
        reg_check("R3 clear keeps ready", 3'd1, 32'h100);

        // R2 mode gating
        reg_write(3'd0, 32'h10);
        reg_check("R2 mode locked", 3'd0, 32'h0);
        set_mode(3'd1);
        reg_check("R2 mode set", 3'd0, 32'h10);
        reg_write(3'd0, 32'h1);
        reg_write(3'd0, 32'h71);
        reg_check("R2 invalid code ignored", 3'd0, 32'h11);
        reg_write(3'd0, 32'h10);

        // R5 single program
        arr_store(3, 32'hA5A5_0F0F, 4'hF);
        model[3] &= 32'hA5A5_0F0F;
        wait_bit(8, n);
        check("R5 ready low cycles", n, LAT);
        reg_check("R5 eop", 3'd1, 32'h110);
        arr_load("R5 programmed", 3);
        clear_all();
        arr_store(3, 32'hFFFF_00FF, 4'hF);
        model[3] &= 32'hFFFF_00FF;
        wait_bit(8, n);
        arr_load("R5 AND of old and new", 3);

        // R6 compare mode
        set_mode(3'd2);
        clear_all();
        arr_store(3, 32'h0000_FFFF, 4'hF);
        model[3] &= 32'h0000_FFFF;
        wait_bit(8, n);
        reg_check("R6 mismatch set", 3'd1, 32'h118);
        clear_all();
        arr_store(10, 32'h1234_5678, 4'hF);
        model[10] = 32'h1234_5678;
        wait_bit(8, n);
        reg_check("R6 no mismatch", 3'd1, 32'h110);
        arr_load("R6 word 10", 10);

        // R11 partial byte enable
        set_mode(3'd1);
        clear_all();
        arr_store(11, 32'h0, 4'h3);
        reg_check("R11 size error", 3'd1, 32'h114);
        arr_load("R11 array unchanged", 11);

        // R10 protection window
        clear_all();
        reg_write(3'd4, 32'hFFF0_0040);
        reg_check("R10 start masked", 3'd4, 32'h40);
        reg_write(3'd5, 32'h4F);
        arr_store(17, 32'h0, 4'hF);
        reg_check("R10 protected", 3'd1, 32'h112);
        arr_load("R10 array unchanged", 17);
        clear_all();
        arr_store(20, 32'h0F0F_0F0F, 4'hF);
        model[20] = 32'h0F0F_0F0F;
        wait_bit(8, n);
        reg_check("R10 outside window", 3'd1, 32'h110);
        arr_load("R10 word 20", 20);

        // R12 collision during operation
        clear_all();
        arr_store(21, 32'hCAFE_F00D, 4'hF);
        arr_load("R12 read during busy returns old", 21);
        arr_store(22, 32'h0, 4'hF);
        model[21] = 32'hCAFE_F00D;
        wait_bit(8, n);
        reg_check("R12 collision and eop", 3'd1, 32'h130);
        arr_load("R12 word 21", 21);
        arr_load("R12 dropped store", 22);

        // R13 interrupts
        reg_write(3'd3, 32'h2);
        check("R13 irq on eop", {31'd0, irq}, 32'd1);
        clear_all();
        check("R13 irq cleared", {31'd0, irq}, 32'd0);
        reg_write(3'd3, 32'h1);
        arr_store(17, 32'h0, 4'hF);
        check("R13 irq on error", {31'd0, irq}, 32'd1);
        clear_all();
        check("R13 irq low", {31'd0, irq}, 32'd0);
        reg_write(3'd3, 32'h0);

        // R7 sequence burst
        set_mode(3'd3);
        reg_check("R7 ready before burst", 3'd1, 32'h100);
        arr_store(24, 32'h1111_2222, 4'hF);
        model[24] = 32'h1111_2222;
        wait_bit(4, n);
        reg_check("R7 eop, ready low", 3'd1, 32'h010);
        arr_store(25, 32'h0000_3333, 4'hF);
        reg_check("R7 store with eop set dropped", 3'd1, 32'h030);
        clear_all();
        arr_store(25, 32'h3333_4444, 4'hF);
        model[25] = 32'h3333_4444;
        wait_bit(4, n);
        reg_check("R7 second word eop", 3'd1, 32'h010);
        clear_all();
        set_mode(3'd0);
        reg_check("R7 ready after leaving", 3'd1, 32'h100);
        arr_load("R7 word 24", 24);
        arr_load("R7 word 25", 25);

        // R8 sector erase
        set_mode(3'd4);
        reg_write(3'd4, 32'h60);
        reg_write(3'd5, 32'h60);
        arr_store(24, 32'h0, 4'hF);
        reg_check("R10 sector erase protected", 3'd1, 32'h112);
        clear_all();
        reg_write(3'd4, 32'hFFFFF);
        reg_write(3'd5, 32'h0);
        arr_store(17, 32'h1234_5678, 4'hF);
        for (int i = 16; i < 32; i++) model[i] = 32'hFFFF_FFFF;
        wait_bit(8, n);
        check("R8 ready low cycles", n, LAT);
        arr_load("R8 word 24 erased", 24);
        arr_load("R8 word 20 erased", 20);
        arr_load("R8 word 10 kept", 10);

        // R9 full erase
        set_mode(3'd5);
        clear_all();
        reg_write(3'd4, 32'h0);
        reg_write(3'd5, 32'h0);
        arr_store(40, 32'h0, 4'hF);
        reg_check("R10 full erase refused", 3'd1, 32'h112);
        arr_load("R10 word 3 kept", 3);
        clear_all();
        reg_write(3'd4, 32'hFFFFF);
        arr_store(40, 32'h0, 4'hF);
        for (int i = 0; i < 64; i++) model[i] = 32'hFFFF_FFFF;
        wait_bit(8, n);
        reg_check("R9 eop", 3'd1, 32'h110);
        arr_load("R9 word 3 erased", 3);
        arr_load("R9 word 10 erased", 10);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("R14 reads outstanding", exp_q.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule